// File: doc/BRIEF.md
# Instruction-Count Interval Timer

This block produces a periodic timer interrupt request whose period is measured in instructions that the processor retires while running unprivileged code. Clock cycles, stalls and instructions retired in privileged mode do not advance it. The core reports every retirement through a strobe, together with the mode in force for that instruction and the mode that follows it. The period length comes from an external configuration input. When the period is reached, the block raises a request that carries a fixed timer vector number. The request stays up until the core acknowledges it.

One timing rule needs care. Suppose the instruction that completes the period also moves the core into privileged mode, for example a trap or a system call. Then the request is not raised at once. It is parked as deferred and released when the core retires the privileged instruction that returns to unprivileged mode. That way the interrupt is taken before the next unprivileged instruction runs. An acknowledge starts a fresh period from zero. A tick value of zero turns the timer off.

Top module: `instr_tick_timer`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the request, the deferred state and the instruction count. After reset, a full `tick_limit` counted instructions are needed before a request.
- R2: Only cycles with `retire`=1 and `cur_user`=1 advance the count. Idle cycles and retirements with `cur_user`=0 leave the count unchanged.
- R3: When the counted instruction that brings the count to `tick_limit` has `next_user`=1, `irq` is 1 one clock after that retirement. `irq` is 0 after every earlier counted instruction of the period.
- R4: When that instruction has `next_user`=0, `irq` stays 0 while privileged instructions retire. `irq` becomes 1 one clock after a retirement with `cur_user`=0 and `next_user`=1.
- R5: Once raised, `irq` stays 1 until `irq_ack` is sampled high. One clock after the acknowledge, `irq` is 0.
- R6: An acknowledge, whether or not a request is up, restarts the count at zero. Reaching the limit also restarts the count at zero.
- R7: Completing another period while `irq` is still 1 is merged into the pending request. After one acknowledge, `irq` stays 0 until a further `tick_limit` counted instructions have retired.
- R8: With `tick_limit`=0, no request is ever raised, however many instructions retire.
- R9: `irq_vec` equals `TIMER_VEC` (default 1) while `irq` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | One instruction retires this cycle |
| cur_user | input | 1 | Retiring instruction ran in unprivileged mode |
| next_user | input | 1 | Mode after the retiring instruction is unprivileged |
| tick_limit | input | CNT_W | Instructions per period; 0 disables |
| irq_ack | input | 1 | Core takes the timer interrupt |
| irq | output | 1 | Timer interrupt request |
| irq_vec | output | VEC_W | Interrupt number while a request is up, else 0 |

## Verification
Every result of this block comes from a flop that one rising edge updates. A request is therefore due one clock after the retirement that completes a period, or after the retirement that returns to unprivileged mode. The clear is due one clock after the acknowledge, and the reset state one clock after reset is sampled. The bench applies each stimulus at a falling edge and samples `irq` and `irq_vec` at the next falling edge, so exactly one rising edge lies between cause and check. It sweeps tick limits from 1 to 6 through the plain, deferred, merged, mid-period acknowledge and mid-period reset cases. The expected request instant is computed from the loop count.

// File: rtl/itt_pkg.sv
package itt_pkg;

  // Qualified view of one retirement
  typedef struct packed {
    logic count_en;   // unprivileged retirement with timer enabled
    logic back_user;  // privileged retirement that returns to unprivileged
  } retire_evt_t;

  function automatic retire_evt_t classify(input logic retire,
                                           input logic cur_user,
                                           input logic next_user,
                                           input logic enabled);
    retire_evt_t e;
    e.count_en  = retire & cur_user & enabled;
    e.back_user = retire & ~cur_user & next_user;
    return e;
  endfunction

endpackage

// File: rtl/itt_count.sv
module itt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // >= keeps a shrunken limit from letting the count run past it
  assign expire  = step && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (expire) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/itt_pend.sv
module itt_pend (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic next_user,
  input  logic back_user,
  input  logic ack,
  output logic irq_q,
  output logic defer_q
);

  always_ff @(posedge clk) begin
    if (rst || ack) begin
      irq_q   <= 1'b0;
      defer_q <= 1'b0;
    end else if (expire && next_user) begin
      irq_q   <= 1'b1;
      defer_q <= 1'b0;
    end else if (defer_q && back_user) begin
      irq_q   <= 1'b1;
      defer_q <= 1'b0;
    end else if (expire && !next_user && !irq_q) begin
      defer_q <= 1'b1;
    end
  end

endmodule

// File: rtl/instr_tick_timer.sv
module instr_tick_timer #(
  parameter int CNT_W     = 16,
  parameter int VEC_W     = 5,
  parameter int TIMER_VEC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             cur_user,
  input  logic             next_user,
  input  logic [CNT_W-1:0] tick_limit,
  input  logic             irq_ack,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);

  import itt_pkg::*;

  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(TIMER_VEC);

  retire_evt_t evt;
  logic        expire;
  logic        defer_q;

  assign evt = classify(retire, cur_user, next_user, tick_limit != '0);

  itt_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .step   (evt.count_en),
    .clear  (irq_ack),
    .limit  (tick_limit),
    .expire (expire)
  );

  itt_pend u_pend (
    .clk       (clk),
    .rst       (rst),
    .expire    (expire),
    .next_user (next_user),
    .back_user (evt.back_user),
    .ack       (irq_ack),
    .irq_q     (irq),
    .defer_q   (defer_q)
  );

  assign irq_vec = irq ? VEC_VAL : '0;

endmodule

// File: rtl/itt_chk.sv
module itt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             retire,
  input logic             cur_user,
  input logic             next_user,
  input logic [CNT_W-1:0] tick_limit,
  input logic             irq_ack,
  input logic             irq,
  input logic             defer_q
);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq);  // R5

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);  // R5

  AST_RISE_AFTER_USER_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(retire && next_user)) |=> !irq);  // R4

  AST_DEFER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    defer_q |-> !irq);  // R4

  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (tick_limit == '0 && !irq && !defer_q) |=> !irq);  // R8

  AST_NO_PRIV_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!irq && !defer_q && !(retire && cur_user)) |=> !defer_q);  // R2

endmodule

bind instr_tick_timer itt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .retire     (retire),
  .cur_user   (cur_user),
  .next_user  (next_user),
  .tick_limit (tick_limit),
  .irq_ack    (irq_ack),
  .irq        (irq),
  .defer_q    (defer_q)
);

// File: tb/instr_tick_timer_test.sv
`timescale 1ns/1ps
module instr_tick_timer_test;

  localparam int CNT_W = 16;
  localparam int VEC_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             retire = 1'b0;
  logic             cur_user = 1'b0;
  logic             next_user = 1'b0;
  logic [CNT_W-1:0] tick_limit = '0;
  logic             irq_ack = 1'b0;
  logic             irq;
  logic [VEC_W-1:0] irq_vec;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  instr_tick_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W), .TIMER_VEC(1)) uut (
    .clk(clk), .rst(rst), .retire(retire), .cur_user(cur_user),
    .next_user(next_user), .tick_limit(tick_limit), .irq_ack(irq_ack),
    .irq(irq), .irq_vec(irq_vec)
  );

  // Apply one cycle of stimulus at a falling edge, return at the next one
  task automatic step(input logic r, input logic cu, input logic nu, input logic ak);
    retire = r; cur_user = cu; next_user = nu; irq_ack = ak;
    @(negedge clk);
    retire = 1'b0; cur_user = 1'b0; next_user = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic chk(input string req, input logic exp_irq);
    int exp_vec;
    exp_vec = exp_irq ? 1 : 0;
    tests++;
    if (irq !== exp_irq || int'(irq_vec) != exp_vec) begin
      fails++;
      $display("FAIL %s limit=%0d: irq=%b vec=%0d expected irq=%b vec=%0d",
               req, tick_limit, irq, irq_vec, exp_irq, exp_vec);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic user_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 1, 0);
      chk(req, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int n = 1; n <= 6; n++) begin
      tick_limit = CNT_W'(n);
      do_reset();
      chk("R1", 1'b0);

      // R2/R3: privileged retirements and idle cycles interleaved
      for (int i = 1; i <= n; i++) begin
        step(1, 0, 0, 0); chk("R2", 1'b0);
        step(0, 1, 1, 0); chk("R2", 1'b0);
        step(1, 1, 1, 0);
        chk((i == n) ? "R3" : "R2", i == n);
      end
      chk("R9", 1'b1);
      for (int i = 0; i < 3; i++) begin
        step(0, 0, 0, 0); chk("R5", 1'b1);
      end
      step(0, 0, 0, 1); chk("R5", 1'b0);

      // R4: deferral across privileged execution
      user_n(n - 1, "R4");
      step(1, 1, 0, 0); chk("R4", 1'b0);
      step(1, 0, 0, 0); chk("R4", 1'b0);
      step(0, 0, 0, 0); chk("R4", 1'b0);
      step(1, 0, 0, 0); chk("R4", 1'b0);
      step(1, 0, 1, 0); chk("R4", 1'b1);
      step(0, 0, 0, 1); chk("R5", 1'b0);

      // R7: second period merged into the pending request
      for (int i = 1; i <= 2 * n; i++) begin
        step(1, 1, 1, 0);
        chk("R7", i >= n);
      end
      step(0, 0, 0, 1); chk("R7", 1'b0);
      user_n(n - 1, "R7");
      step(1, 1, 1, 0); chk("R7", 1'b1);
      step(0, 0, 0, 1); chk("R5", 1'b0);

      // R6: acknowledge mid-period restarts the count
      user_n(n - 1, "R6");
      step(0, 0, 0, 1); chk("R6", 1'b0);
      user_n(n - 1, "R6");
      step(1, 1, 1, 0); chk("R6", 1'b1);
      step(0, 0, 0, 1); chk("R6", 1'b0);

      // R1: reset mid-period restarts the count
      user_n(n - 1, "R1");
      do_reset();
      chk("R1", 1'b0);
      user_n(n - 1, "R1");
      step(1, 1, 1, 0); chk("R1", 1'b1);
      step(0, 0, 0, 1); chk("R5", 1'b0);
    end

    // R8: zero limit disables the timer
    tick_limit = '0;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step(1, 1, (i % 3) != 0, 0);
      chk("R8", 1'b0);
    end
    step(1, 0, 1, 0); chk("R8", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule